// File: doc/BRIEF.md
# Processor Interrupt Level Resolver

This block decides which pending interrupt level a processor core should take next and presents it as a hard-interrupt request with a trap-type code. Level requests arrive from external sources and from a software-writable soft-interrupt register. Two timer-match flags in that register do not stand for levels of their own; either one posts level 14. Each clock the block evaluates the pending set against the processor interrupt level (PIL), the global enable, the trap now running and a vector-interrupt busy flag. The decision is registered, so the outputs follow the inputs by one cycle.

A core uses the outputs to enter a trap. The block holds its request while a vector interrupt is busy, because vector interrupts outrank all level interrupts. It also holds while a numerically higher external-interrupt trap is still being handled at a nonzero trap level, so a lower level cannot preempt it.

Top module: `irl_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_req` is 0 and `irq_tt` is 0.
- R2: The pending set is the OR of `ext_lvl[15:0]` and `soft_int[15:1]` (bit n for level n). The timer bits `soft_int[0]` (tick match) and `soft_int[16]` (system-tick match) are not counted as levels.
- R3: If `soft_int[0]` or `soft_int[16]` is 1, level 14 is pending.
- R4: In the cycle after any cycle with `vec_busy` = 1, `irq_req` and `irq_tt` keep their previous values.
- R5: When `vec_busy` = 0 and no pending level is numerically greater than `pil`, both outputs are 0 in the next cycle, whatever the enable.
- R6: When `vec_busy` = 0, `int_en` = 1 and some level above `pil` is pending, the highest such level L is selected. One cycle later `irq_tt` = 0x40 + L and `irq_req` = 1, unless R7 applies.
- R7: If `trap_lvl` is nonzero and `cur_tt[8:4]` = 0x4 (an external-interrupt trap) and `cur_tt` is greater than 0x40 + L, the outputs are held unchanged.
- R8: If the selected code equals the code already held, the outputs are held unchanged.
- R9: When `vec_busy` = 0, `int_en` = 0, a level above `pil` is pending and `irq_req` = 1, both outputs become 0 in the next cycle.
- R10: Whenever `irq_req` is 0, `irq_tt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_lvl | input | 16 | External level requests, bit n = level n |
| soft_int | input | 17 | Soft-interrupt register: bit 0 tick match, bits 15:1 soft levels, bit 16 system-tick match |
| pil | input | 4 | Current processor interrupt level |
| int_en | input | 1 | Global interrupt enable |
| trap_lvl | input | 3 | Current trap nesting level |
| cur_tt | input | 9 | Trap type of the trap now running |
| vec_busy | input | 1 | Vector interrupt pending; freezes the outputs |
| irq_req | output | 1 | Hard-interrupt request |
| irq_tt | output | 9 | Trap-type code of the selected level (0x41 to 0x4F), or 0 |

## Verification
A corrupted held code shows up one cycle later in one of two ways. The request can stay asserted with a stale `irq_tt`. Or a legitimate new level can be suppressed because R8 wrongly sees it as already held. Both can be seen at the ports on the cycle after the pending set changes. A wrong PIL mask or a wrong priority order gives the wrong level code in the very next cycle. The nesting guard and the busy freeze show as outputs that move when they should be stable. The scoreboard therefore compares both outputs every cycle under directed corner cases and a long random stream.

// File: rtl/irl_pkg.sv
package irl_pkg;
   localparam int IRL_LVL_N   = 16;
   localparam int IRL_TT_W    = 9;
   localparam int IRL_TL_W    = 3;
   localparam int IRL_EXT_BASE = 'h40;
   localparam int IRL_TIMER_LVL = 14;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_CLEAR = 2'd1,
      ACT_LOAD  = 2'd2
   } irl_act_e;
endpackage

// File: rtl/irl_pending.sv
module irl_pending #(
   parameter int LVL_N     = 16,
   parameter int TIMER_LVL = 14,
   localparam int SOFT_W   = LVL_N + 1
) (
   input  logic [LVL_N-1:0]  ext_lvl,
   input  logic [SOFT_W-1:0] soft_int,
   output logic [LVL_N-1:0]  pend
);
   localparam int TICK_BIT  = 0;
   localparam int STICK_BIT = LVL_N;

   logic [LVL_N-1:0] soft_lv;
   logic             timer_hit;

   always_comb begin
      soft_lv           = soft_int[LVL_N-1:0];
      soft_lv[TICK_BIT] = 1'b0;
   end

   assign timer_hit = soft_int[TICK_BIT] | soft_int[STICK_BIT];

   genvar g;
   generate
      for (g = 0; g < LVL_N; g++) begin : g_lvl
         if (g == TIMER_LVL) begin : g_tmr
            assign pend[g] = ext_lvl[g] | soft_lv[g] | timer_hit;
         end else begin : g_plain
            assign pend[g] = ext_lvl[g] | soft_lv[g];
         end
      end
   endgenerate
endmodule

// File: rtl/irl_above_mask.sv
module irl_above_mask #(
   parameter int LVL_N   = 16,
   localparam int LVL_W  = $clog2(LVL_N)
) (
   input  logic [LVL_W-1:0] pil,
   output logic [LVL_N-1:0] mask
);
   genvar g;
   generate
      for (g = 0; g < LVL_N; g++) begin : g_bit
         assign mask[g] = (LVL_W'(g) > pil);
      end
   endgenerate
endmodule

// File: rtl/irl_prio_enc.sv
module irl_prio_enc #(
   parameter int LVL_N  = 16,
   localparam int LVL_W = $clog2(LVL_N)
) (
   input  logic [LVL_N-1:0] vec,
   output logic             found,
   output logic [LVL_W-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = 0; i < LVL_N; i++) begin
         if (vec[i]) begin
            found = 1'b1;
            idx   = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/irl_resolver.sv
module irl_resolver
   import irl_pkg::*;
#(
   parameter int LVL_N     = IRL_LVL_N,
   parameter int TT_W      = IRL_TT_W,
   parameter int TL_W      = IRL_TL_W,
   parameter int EXT_BASE  = IRL_EXT_BASE,
   parameter int TIMER_LVL = IRL_TIMER_LVL,
   localparam int LVL_W    = $clog2(LVL_N),
   localparam int SOFT_W   = LVL_N + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_N-1:0]  ext_lvl,
   input  logic [SOFT_W-1:0] soft_int,
   input  logic [LVL_W-1:0]  pil,
   input  logic              int_en,
   input  logic [TL_W-1:0]   trap_lvl,
   input  logic [TT_W-1:0]   cur_tt,
   input  logic              vec_busy,
   output logic              irq_req,
   output logic [TT_W-1:0]   irq_tt
);
   localparam logic [TT_W-1:0] BASE_C = TT_W'(EXT_BASE);

   generate
      if ((1 << LVL_W) != LVL_N) begin : g_chk_pow2
         $error("irl_resolver: LVL_N must be a power of two");
      end
      if (TT_W <= LVL_W) begin : g_chk_ttw
         $error("irl_resolver: TT_W must exceed the level index width");
      end
      if ((EXT_BASE % LVL_N) != 0 || EXT_BASE >= (1 << TT_W)) begin : g_chk_base
         $error("irl_resolver: EXT_BASE must be level-aligned and fit TT_W");
      end
      if (TIMER_LVL < 1 || TIMER_LVL >= LVL_N) begin : g_chk_tmr
         $error("irl_resolver: TIMER_LVL out of range");
      end
   endgenerate

   logic [LVL_N-1:0] pend, above, cand;
   logic             any_above;
   logic [LVL_W-1:0] hi_lvl;
   logic [TT_W-1:0]  new_tt;
   logic             cur_is_ext, nest_block;
   logic             req_q;
   logic [TT_W-1:0]  tt_q;
   irl_act_e         act;

   irl_pending #(.LVL_N(LVL_N), .TIMER_LVL(TIMER_LVL)) u_pend (
      .ext_lvl (ext_lvl),
      .soft_int(soft_int),
      .pend    (pend)
   );

   irl_above_mask #(.LVL_N(LVL_N)) u_mask (
      .pil (pil),
      .mask(above)
   );

   assign cand = pend & above;

   irl_prio_enc #(.LVL_N(LVL_N)) u_enc (
      .vec  (cand),
      .found(any_above),
      .idx  (hi_lvl)
   );

   assign new_tt     = BASE_C | {{(TT_W-LVL_W){1'b0}}, hi_lvl};
   assign cur_is_ext = (cur_tt[TT_W-1:LVL_W] == BASE_C[TT_W-1:LVL_W]);
   assign nest_block = (trap_lvl != '0) && cur_is_ext && (cur_tt > new_tt);

   always_comb begin
      act = ACT_HOLD;
      if (vec_busy) begin
         act = ACT_HOLD;
      end else if (!any_above) begin
         act = ACT_CLEAR;
      end else if (int_en) begin
         if (nest_block)           act = ACT_HOLD;
         else if (new_tt != tt_q)  act = ACT_LOAD;
         else                      act = ACT_HOLD;
      end else if (req_q) begin
         act = ACT_CLEAR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         tt_q  <= '0;
      end else begin
         unique case (act)
            ACT_CLEAR: begin
               req_q <= 1'b0;
               tt_q  <= '0;
            end
            ACT_LOAD: begin
               req_q <= 1'b1;
               tt_q  <= new_tt;
            end
            default: begin
               req_q <= req_q;
               tt_q  <= tt_q;
            end
         endcase
      end
   end

   assign irq_req = req_q;
   assign irq_tt  = tt_q;
endmodule

// File: rtl/irl_resolver_chk.sv
module irl_resolver_chk #(
   parameter int LVL_N     = 16,
   parameter int TT_W      = 9,
   parameter int TL_W      = 3,
   parameter int EXT_BASE  = 'h40,
   parameter int TIMER_LVL = 14,
   localparam int LVL_W    = $clog2(LVL_N),
   localparam int SOFT_W   = LVL_N + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LVL_N-1:0]  ext_lvl,
   input logic [SOFT_W-1:0] soft_int,
   input logic [LVL_W-1:0]  pil,
   input logic              int_en,
   input logic [TL_W-1:0]   trap_lvl,
   input logic [TT_W-1:0]   cur_tt,
   input logic              vec_busy,
   input logic              irq_req,
   input logic [TT_W-1:0]   irq_tt
);
   logic [LVL_N-1:0] c_pend;
   logic             c_any;
   logic [TT_W-1:0]  c_top_tt;

   always_comb begin
      c_pend = ext_lvl;
      for (int i = 1; i < LVL_N; i++) c_pend[i] = c_pend[i] | soft_int[i];
      if (soft_int[0] || soft_int[LVL_N]) c_pend[TIMER_LVL] = 1'b1;
      c_any    = 1'b0;
      c_top_tt = '0;
      for (int i = 0; i < LVL_N; i++) begin
         if (c_pend[i] && (i > int'(pil))) begin
            c_any    = 1'b1;
            c_top_tt = TT_W'(EXT_BASE + i);
         end
      end
   end

   // R1
   p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !irq_req && irq_tt == '0);

   // R10
   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> irq_tt == '0);

   // R4
   p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_busy |=> $stable(irq_req) && $stable(irq_tt));

   // R5
   p_below_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_busy && !c_any |=> !irq_req && irq_tt == '0);

   // R6
   p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> irq_tt > TT_W'(EXT_BASE) && irq_tt < TT_W'(EXT_BASE + LVL_N));

   // R9
   p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_busy && !int_en && irq_req |=> !irq_req);

   // R7
   p_nest_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_busy && c_any && int_en && trap_lvl != '0
      && cur_tt[TT_W-1:LVL_W] == TT_W'(EXT_BASE) >> LVL_W && cur_tt > c_top_tt
      |=> $stable(irq_tt));
endmodule

bind irl_resolver irl_resolver_chk #(
   .LVL_N(LVL_N), .TT_W(TT_W), .TL_W(TL_W),
   .EXT_BASE(EXT_BASE), .TIMER_LVL(TIMER_LVL)
) u_chk (.*);

// File: tb/irl_resolver_tb.sv
module irl_resolver_tb;
   localparam int CLK_P = 10;

   typedef struct {
      logic       req;
      logic [8:0] tt;
      string      tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] ext_lvl = '0;
   logic [16:0] soft_int = '0;
   logic [3:0]  pil = '0;
   logic        int_en = 1'b0;
   logic [2:0]  trap_lvl = '0;
   logic [8:0]  cur_tt = '0;
   logic        vec_busy = 1'b0;
   logic        irq_req;
   logic [8:0]  irq_tt;

   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;
   exp_t sb_q[$];

   logic       m_req = 1'b0;
   logic [8:0] m_tt = '0;

   always #(CLK_P/2) clk = ~clk;

   irl_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .ext_lvl(ext_lvl), .soft_int(soft_int),
      .pil(pil), .int_en(int_en), .trap_lvl(trap_lvl), .cur_tt(cur_tt),
      .vec_busy(vec_busy), .irq_req(irq_req), .irq_tt(irq_tt)
   );

   // model of the requirements
   task automatic model_step();
      logic [15:0] p;
      int          hi;
      logic [8:0]  ntt;
      p = ext_lvl | {soft_int[15:1], 1'b0};                 // R2
      if (soft_int[0] || soft_int[16]) p[14] = 1'b1;         // R3
      hi = -1;
      for (int i = 0; i < 16; i++) if (p[i] && i > int'(pil)) hi = i;
      if (vec_busy) return;                                  // R4
      if (hi < 0) begin m_req = 0; m_tt = 0; return; end    // R5
      ntt = 9'h40 + 9'(hi);
      if (int_en) begin
         if (trap_lvl != 0 && cur_tt[8:4] == 5'h4 && cur_tt > ntt) return; // R7
         if (ntt != m_tt) begin m_req = 1; m_tt = ntt; end    // R6, R8
      end else if (m_req) begin
         m_req = 0; m_tt = 0;                                 // R9
      end
   endtask

   task automatic drive(input logic [15:0] e, input logic [16:0] s, input logic [3:0] pl,
                        input logic ie, input logic [2:0] tl, input logic [8:0] ct,
                        input logic vb, input string tag);
      exp_t x;
      @(negedge clk);
      ext_lvl = e; soft_int = s; pil = pl; int_en = ie;
      trap_lvl = tl; cur_tt = ct; vec_busy = vb;
      model_step();
      x.req = m_req; x.tt = m_tt; x.tag = tag;
      sb_q.push_back(x);
   endtask

   always @(posedge clk) begin
      #(CLK_P/4);
      if (sb_q.size() > 0) begin
         exp_t x;
         x = sb_q.pop_front();
         n_chk++;
         if (irq_req !== x.req || irq_tt !== x.tt) begin
            n_fail++;
            $display("FAIL %s: req=%0b tt=0x%0h expected req=%0b tt=0x%0h",
                     x.tag, irq_req, irq_tt, x.req, x.tt);
         end
      end
   end

   initial begin
      #(CLK_P*100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (irq_req !== 1'b0 || irq_tt !== 9'h0) begin
         n_fail++;
         $display("FAIL R1: req=%0b tt=0x%0h expected req=0 tt=0x0", irq_req, irq_tt);
      end
      rst_n = 1'b1;
      drive(16'h0, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R1");
      drive(16'h0020, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R6");
      drive(16'h0220, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R6");
      drive(16'h0200, 17'h01000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R2");
      drive(16'h0200, 17'h01000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R8");
      drive(16'h0, 17'h00001, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R3");
      drive(16'h0, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R8");
      drive(16'h0, 17'h10000, 4'd15, 1'b1, 3'd0, 9'h0, 1'b0, "R5");
      drive(16'h0, 17'h10000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R3");
      drive(16'h8000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b1, "R4");
      drive(16'h0, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b1, "R4");
      drive(16'h8000, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R6");
      drive(16'h2000, 17'h0, 4'd13, 1'b1, 3'd0, 9'h0, 1'b0, "R5");
      drive(16'h4000, 17'h0, 4'd13, 1'b1, 3'd0, 9'h0, 1'b0, "R6");
      drive(16'h0008, 17'h0, 4'd0, 1'b1, 3'd1, 9'h04F, 1'b0, "R7");
      drive(16'h0008, 17'h0, 4'd0, 1'b1, 3'd1, 9'h020, 1'b0, "R7");
      drive(16'h0010, 17'h0, 4'd0, 1'b1, 3'd0, 9'h04F, 1'b0, "R7");
      drive(16'h0010, 17'h0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b0, "R9");
      drive(16'h0010, 17'h0, 4'd0, 1'b0, 3'd0, 9'h0, 1'b0, "R10");
      drive(16'h0030, 17'h0, 4'd4, 1'b1, 3'd0, 9'h0, 1'b0, "R6");
      drive(16'h0030, 17'h0, 4'd5, 1'b1, 3'd0, 9'h0, 1'b0, "R5");
      drive(16'h0001, 17'h00001, 4'd13, 1'b1, 3'd0, 9'h0, 1'b0, "R3");
      drive(16'h0001, 17'h00000, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R2");
      for (int k = 0; k < 400; k++) begin
         drive(16'($urandom), 17'($urandom) & 17'h1_0F0F, 4'($urandom_range(0, 15)),
               ($urandom_range(0, 7) != 0), 3'($urandom_range(0, 2)),
               9'h40 + 9'($urandom_range(0, 15)), ($urandom_range(0, 9) == 0), "R6");
      end
      drive(16'h0, 17'h0, 4'd0, 1'b1, 3'd0, 9'h0, 1'b0, "R5");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule